// File: doc/BRIEF.md
# Column Address Strobe Sequencer

This block drives the active-low column address strobe of a memory controller that shares DRAM between a CPU and a video fetch engine. It runs on a fast system clock. A single falling edge of a cycle-sync input marks the start of each memory cycle. After a fixed lead-in, the strobe opens a CPU window. During that window the strobe follows the memory-request input, resampled at a fixed step. A timed video-fetch tail follows, which pulses the strobe low twice on every cycle no matter what the CPU is doing.

The CPU request arrives with no timing relation to the sequencer, so it passes through a flop synchronizer. The window samples it repeatedly instead of once, so a request that rises or falls part way through the window is still followed. Once the tail finishes, the block goes idle. It waits for the next true high-to-low transition of the sync input and does not restart on a sync level that is held low.

Top module: `colstrobe_seq`

## Requirements
- R1: After a synchronous reset, and in the idle state, `strobe_n_o` is high (1).
- R2: Call the first rising clock edge at which `cyc_sync_i` is sampled 0, having been sampled 1 at the edge before, edge E0. `strobe_n_o` stays high through the 25 edges E1..E25. It first shows the CPU window value after edge E26.
- R3: The CPU window lasts 33 clocks (11 steps of 3 clocks), shown after edges E26..E58. In that window `strobe_n_o` equals the synchronized `mreq_n_i`, 0 when the request is active.
- R4: After the window, `strobe_n_o` is forced high for exactly 25 clocks (after edges E59..E83).
- R5: It is then forced low for exactly 25 clocks (after edges E84..E108).
- R6: It is then forced high for exactly 15 clocks (after edges E109..E123).
- R7: It is then forced low for exactly 30 clocks (after edges E124..E153), and is high from E154 until the next cycle starts.
- R8: The two forced-low video pulses occur whatever `mreq_n_i` does. With `mreq_n_i` held at 1, those pulses are the only low periods.
- R9: A new cycle starts only from idle on a new high-to-low sync transition. A sync falling edge during a running sequence is ignored, and a sync held low after a cycle ends does not restart it.
- R10: `mreq_n_i` passes through two flops before it is sampled. A change of request in mid-window reaches the strobe within at most two synchronizer clocks plus one step plus the output register.
- R11: Reset asserted in mid-sequence returns the strobe to high on the next clock, and the block stays idle until a new sync falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_sync_i | input | 1 | Cycle sync; its falling edge starts a memory cycle |
| mreq_n_i | input | 1 | CPU memory request, active low, asynchronous |
| strobe_n_o | output | 1 | Column address strobe, active low, registered |

## Verification
The hardest case to reach is a sync falling edge that lands while a sequence is already running, combined with a sync level held low after the sequence ends. Both could wrongly restart the timer. The bench holds sync low from the start of a cycle, raises it and drops it again in the middle of the forced-high phase, and then leaves it low for the rest of the capture. It then checks that the recorded strobe trace is identical to the trace of an undisturbed cycle and stays high afterwards. A second hard case is a request that changes inside the window. The bench flips the request part way through the CPU window and checks both ends of the window, with a margin that allows for synchronizer latency.

// File: rtl/cs_pkg.sv
package cs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LEAD  = 3'd1,
      PH_WIN   = 3'd2,
      PH_VHI1  = 3'd3,
      PH_VLO1  = 3'd4,
      PH_VHI2  = 3'd5,
      PH_VLO2  = 3'd6
   } phase_t;

   function automatic phase_t next_phase(phase_t p);
      case (p)
         PH_LEAD: return PH_WIN;
         PH_WIN:  return PH_VHI1;
         PH_VHI1: return PH_VLO1;
         PH_VLO1: return PH_VHI2;
         PH_VHI2: return PH_VLO2;
         default: return PH_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic cyc_sync_i,
   input  logic mreq_n_i,
   output logic fall_o,
   output logic mreq_s_o
);

   logic sync_prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) sync_prev_q <= 1'b0;
      else       sync_prev_q <= cyc_sync_i;
   end

   assign fall_o = sync_prev_q & ~cyc_sync_i;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign mreq_s_o = mreq_n_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stage_q;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk_i) begin
               if (rst_i) stage_q[i] <= 1'b1;
               else if (i == 0) stage_q[i] <= mreq_n_i;
               else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
         end
         assign mreq_s_o = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   // R9: a detected fall cannot repeat on the next cycle without sync rising again
   a_r9_fall_needs_rise: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o |=> !fall_o);

endmodule

// File: rtl/cs_phase_seq.sv
module cs_phase_seq
   import cs_pkg::*;
#(
   parameter int LEAD_CLKS  = 25,
   parameter int STEP_CLKS  = 3,
   parameter int STEP_COUNT = 11,
   parameter int VHI1_CLKS  = 25,
   parameter int VLO1_CLKS  = 25,
   parameter int VHI2_CLKS  = 15,
   parameter int VLO2_CLKS  = 30
) (
   input  logic   clk_i,
   input  logic   rst_i,
   input  logic   fall_i,
   input  logic   mreq_s_i,
   output phase_t phase_o,
   output logic   samp_o
);

   localparam int WIN_CLKS = STEP_CLKS * STEP_COUNT;
   localparam int MAX_A    = (LEAD_CLKS > WIN_CLKS) ? LEAD_CLKS : WIN_CLKS;
   localparam int MAX_B    = (VHI1_CLKS > VLO1_CLKS) ? VHI1_CLKS : VLO1_CLKS;
   localparam int MAX_C    = (VHI2_CLKS > VLO2_CLKS) ? VHI2_CLKS : VLO2_CLKS;
   localparam int MAX_AB   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_LEN  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
   localparam int CW       = $clog2(MAX_LEN + 1);
   localparam int SW       = $clog2(STEP_CLKS + 1);

   function automatic logic [CW-1:0] phase_len_m1(phase_t p);
      case (p)
         PH_LEAD: return CW'(LEAD_CLKS - 1);
         PH_WIN:  return CW'(WIN_CLKS - 1);
         PH_VHI1: return CW'(VHI1_CLKS - 1);
         PH_VLO1: return CW'(VLO1_CLKS - 1);
         PH_VHI2: return CW'(VHI2_CLKS - 1);
         PH_VLO2: return CW'(VLO2_CLKS - 1);
         default: return '0;
      endcase
   endfunction

   phase_t        ph_q;
   logic [CW-1:0] cnt_q;
   logic [SW-1:0] step_q;
   logic          samp_q;
   phase_t        ph_nx;

   assign ph_nx = next_phase(ph_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         step_q <= '0;
         samp_q <= 1'b1;
      end else if (ph_q == PH_IDLE) begin
         if (fall_i) begin
            ph_q  <= PH_LEAD;
            cnt_q <= phase_len_m1(PH_LEAD);
         end
      end else if (cnt_q == '0) begin
         ph_q  <= ph_nx;
         cnt_q <= phase_len_m1(ph_nx);
         if (ph_nx == PH_WIN) begin
            samp_q <= mreq_s_i;
            step_q <= SW'(STEP_CLKS - 1);
         end
      end else begin
         cnt_q <= cnt_q - 1'b1;
         if (ph_q == PH_WIN) begin
            if (step_q == '0) begin
               step_q <= SW'(STEP_CLKS - 1);
               samp_q <= mreq_s_i;
            end else begin
               step_q <= step_q - 1'b1;
            end
         end
      end
   end

   assign phase_o = ph_q;
   assign samp_o  = samp_q;

   // R9: the lead-in phase is only ever entered from idle
   a_r9_start_from_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q == PH_LEAD && $past(ph_q) != PH_LEAD) |-> $past(ph_q) == PH_IDLE);

   // R3: the held request sample changes only at step boundaries
   a_r3_step_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q == PH_WIN && step_q != '0 && cnt_q != '0) |=> samp_q == $past(samp_q));

   // R4: the first forced-high phase always follows the CPU window
   a_r4_after_window: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q == PH_VHI1 && $past(ph_q) != PH_VHI1) |-> $past(ph_q) == PH_WIN);

   // R7: the sequence returns to idle only from the last low pulse
   a_r7_end_to_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q == PH_IDLE && $past(ph_q) != PH_IDLE) |-> $past(ph_q) == PH_VLO2);

endmodule

// File: rtl/cs_strobe_drv.sv
module cs_strobe_drv
   import cs_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_i,
   input  phase_t phase_i,
   input  logic   samp_i,
   output logic   strobe_n_o
);

   logic strobe_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         strobe_q <= 1'b1;
      end else begin
         case (phase_i)
            PH_WIN:           strobe_q <= samp_i;
            PH_VLO1, PH_VLO2: strobe_q <= 1'b0;
            default:          strobe_q <= 1'b1;
         endcase
      end
   end

   assign strobe_n_o = strobe_q;

   // R5, R7: video pulse phases drive the strobe low one clock later
   a_r5_video_low: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_i == PH_VLO1 || phase_i == PH_VLO2) |=> !strobe_n_o);

   // R1, R4, R6: idle, lead-in and forced-high phases give a high strobe
   a_r1_rest_high: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_i == PH_IDLE || phase_i == PH_LEAD || phase_i == PH_VHI1 ||
       phase_i == PH_VHI2) |=> strobe_n_o);

endmodule

// File: rtl/colstrobe_seq.sv
module colstrobe_seq
   import cs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LEAD_CLKS   = 25,
   parameter int STEP_CLKS   = 3,
   parameter int STEP_COUNT  = 11,
   parameter int VHI1_CLKS   = 25,
   parameter int VLO1_CLKS   = 25,
   parameter int VHI2_CLKS   = 15,
   parameter int VLO2_CLKS   = 30
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic cyc_sync_i,
   input  logic mreq_n_i,
   output logic strobe_n_o
);

   generate
      if (LEAD_CLKS < 1 || STEP_CLKS < 1 || STEP_COUNT < 1 || VHI1_CLKS < 1 ||
          VLO1_CLKS < 1 || VHI2_CLKS < 1 || VLO2_CLKS < 1) begin : g_bad_len
         $error("colstrobe_seq: every phase length must be at least one clock");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("colstrobe_seq: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic   fall;
   logic   mreq_s;
   phase_t phase;
   logic   samp;

   cs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .cyc_sync_i (cyc_sync_i),
      .mreq_n_i   (mreq_n_i),
      .fall_o     (fall),
      .mreq_s_o   (mreq_s)
   );

   cs_phase_seq #(
      .LEAD_CLKS  (LEAD_CLKS),
      .STEP_CLKS  (STEP_CLKS),
      .STEP_COUNT (STEP_COUNT),
      .VHI1_CLKS  (VHI1_CLKS),
      .VLO1_CLKS  (VLO1_CLKS),
      .VHI2_CLKS  (VHI2_CLKS),
      .VLO2_CLKS  (VLO2_CLKS)
   ) u_seq (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .fall_i   (fall),
      .mreq_s_i (mreq_s),
      .phase_o  (phase),
      .samp_o   (samp)
   );

   cs_strobe_drv u_drv (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .phase_i    (phase),
      .samp_i     (samp),
      .strobe_n_o (strobe_n_o)
   );

   // R11: reset forces the strobe high on the following clock
   a_r11_reset_high: assert property (@(posedge clk_i)
      rst_i |=> strobe_n_o);

   generate
      if (SYNC_STAGES == 2) begin : g_sync_chk
         // R10: the synchronized request lags the pin by two clocks
         a_r10_two_flop: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && !$past(rst_i, 2)) |-> mreq_s == $past(mreq_n_i, 2));
      end
   endgenerate

endmodule

// File: tb/colstrobe_seq_tb_top.sv
module colstrobe_seq_tb_top;

   logic clk = 1'b0;
   logic rst;
   logic sync;
   logic mreq;
   logic strobe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic tr [0:299];

   always #4 clk = ~clk;

   colstrobe_seq dut_i (
      .clk_i      (clk),
      .rst_i      (rst),
      .cyc_sync_i (sync),
      .mreq_n_i   (mreq),
      .strobe_n_o (strobe)
   );

   task automatic check_seg(input string req, input int lo, input int hi, input logic exp);
      int bad = -1;
      n_checks++;
      for (int k = lo; k <= hi; k++) if (tr[k] !== exp && bad < 0) bad = k;
      if (bad >= 0) begin
         n_fail++;
         $display("FAIL %s: trace[%0d]=%b expected %b (segment %0d..%0d)",
                  req, bad, tr[bad], exp, lo, hi);
      end
   endtask

   // captures n samples, one after each clock edge starting at E0
   task automatic capture(input int n, input int mreq_k, input logic mreq_v,
                          input int shi_k, input int slo_k, input int rst_k);
      @(negedge clk) sync = 1'b0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         tr[k] = strobe;
         if (k == mreq_k) mreq = mreq_v;
         if (k == shi_k) sync = 1'b1;
         if (k == slo_k) sync = 1'b0;
         if (k == rst_k) rst = 1'b1;
         if (k == rst_k + 2) rst = 1'b0;
      end
   endtask

   task automatic settle();
      @(negedge clk) sync = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic check_tail(input int last);
      check_seg("R4", 59, 83, 1'b1);
      check_seg("R5", 84, 108, 1'b0);
      check_seg("R6", 109, 123, 1'b1);
      check_seg("R7", 124, 153, 1'b0);
      check_seg("R7", 154, last, 1'b1);
   endtask

   task automatic t_reset();
      rst = 1'b1; sync = 1'b1; mreq = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); tr[k] = strobe; end
      check_seg("R1", 0, 19, 1'b1);
   endtask

   task automatic t_req_active();
      mreq = 1'b0; settle();
      capture(170, -1, 1'b0, -1, -1, -1);
      check_seg("R2", 0, 25, 1'b1);
      check_seg("R3", 26, 58, 1'b0);
      check_tail(169);
   endtask

   task automatic t_req_idle();
      mreq = 1'b1; settle();
      capture(170, -1, 1'b0, -1, -1, -1);
      check_seg("R8", 0, 58, 1'b1);
      check_tail(169);
   endtask

   task automatic t_req_change();
      mreq = 1'b1; settle();
      capture(170, 35, 1'b0, -1, -1, -1);
      check_seg("R10", 26, 36, 1'b1);
      check_seg("R10", 45, 58, 1'b0);
      check_tail(169);
      mreq = 1'b1;
   endtask

   task automatic t_retrigger();
      mreq = 1'b1; settle();
      capture(260, -1, 1'b0, 60, 70, -1);
      check_seg("R9", 0, 58, 1'b1);
      check_tail(259);
   endtask

   task automatic t_reset_mid();
      mreq = 1'b0; settle();
      capture(190, -1, 1'b0, -1, -1, 90);
      check_seg("R5", 85, 90, 1'b0);
      check_seg("R11", 91, 189, 1'b1);
      mreq = 1'b1;
   endtask

   initial begin
      t_reset();
      t_req_active();
      t_req_idle();
      t_req_change();
      t_retrigger();
      t_reset_mid();
      settle();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule